// File: doc/BRIEF.md
# Framed Serial Transmitter with Line Control

This block turns bytes written by software into asynchronous serial frames on a single output line. A line-control word sets how each frame looks: the character length (5 to 8 data bits), one of five parity settings (none, odd, even, forced high, forced low) and whether one or two stop bits close the frame. Characters wait in a small transmit queue. A holding-empty status output lets software poll before each write.

Bit timing comes from an external baud generator. It supplies a one-cycle enable pulse at sixteen times the bit rate, and every bit on the line lasts a fixed number of these pulses. A FIFO-control write can flush the queue or change its usable depth. A flush command acts once and is not stored. While the divisor-access bit of the line-control word is set, data writes belong to the divisor latches and never reach the queue.

Top module: `uart_line_tx`

## Requirements
- R1: After reset the line is high (idle), holding-empty is 1 and overrun is 0. The line-control word resets to zero (5 bits, no parity, one stop bit) and the deep queue is disabled.
- R2: A frame starts with one low start bit, followed by the data bits LSB first. Each bit lasts exactly OVERSAMPLE (16) baud-enable pulses, and the line changes only on a baud-enable pulse once a frame has begun.
- R3: Line-control bits [1:0] select the character length: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Data bits above the selected length are not sent.
- R4: Line-control bits [5:3] select the parity: 0 none, 1 odd (the data bits plus parity hold an odd number of ones), 2 even, 3 parity bit always 1, 4 parity bit always 0. Codes 5 to 7 send no parity bit. When present, the parity bit follows the last data bit.
- R5: Line-control bit [2] set gives two high stop bits; clear gives one.
- R6: A line-control write takes effect at the next character boundary. A character already on the line keeps the framing it started with.
- R7: Holding-empty is 1 exactly when the queue holds no character. A character moves out of the queue, and holding-empty rises, in the cycle after the transmitter picks it up, while that character is still being sent.
- R8: FIFO-control bit [0] set gives a queue of FIFO_DEPTH characters; clear gives a queue of one character.
- R9: A data write while the queue is full is dropped and sets a sticky overrun flag. Only a flush or reset clears the flag.
- R10: A FIFO-control write with bit [1] set empties the queue and clears overrun in one cycle. The character on the line still completes, and characters flushed from the queue are never sent.
- R11: While line-control bit [6] (divisor access) is set, data writes do not enter the queue and produce no frame.
- R12: Characters already queued go out back to back: the next start bit follows the last stop bit of the previous frame with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| lcw_we | input | 1 | Line-control word write strobe |
| lcw_din | input | 7 | Line-control word: [6] divisor access, [5:3] parity, [2] two stop, [1:0] length |
| fctl_we | input | 1 | FIFO-control write strobe |
| fctl_din | input | 2 | [1] flush queue (one-shot), [0] deep queue enable |
| thr_we | input | 1 | Data write strobe |
| thr_din | input | 8 | Character to send |
| txd | output | 1 | Serial output line, idles high |
| thr_empty | output | 1 | Queue holds no character |
| tx_overrun | output | 1 | Sticky: a write was dropped on a full queue |

## Verification
The bench decodes frames straight off the line by counting baud pulses and sampling mid-bit. A wrong bit order, a miscounted length or an inverted parity sense therefore shows up as a mismatched frame. Each parity code is covered, including an unused code, so a design that treated code 6 as a real parity mode would send one extra bit.

Further tests go after framing that slips mid-character and a queue that stalls or inserts an idle gap between queued frames. They also check single-entry depth with FIFO disabled: a design that ignored the enable would miss the overrun on the third write. Other tests cover a flush that kills the character on the line, and a divisor-access write that leaks into the queue.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    // Packed MSB first: [6] div_access, [5:3] par, [2] two_stop, [1:0] len_sel
    typedef struct packed {
        logic      div_access;
        par_mode_e par;
        logic      two_stop;
        logic [1:0] len_sel;
    } line_ctl_t;

    localparam int LCW_W = $bits(line_ctl_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    function automatic logic [3:0] char_bits(logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    function automatic logic [CHAR_W-1:0] keep_low(logic [CHAR_W-1:0] d, logic [1:0] sel);
        logic [CHAR_W-1:0] m;
        m = 8'hFF >> (2'd3 - sel);
        return d & m;
    endfunction

    function automatic logic parity_on(par_mode_e m);
        return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_MARK) || (m == PAR_SPACE);
    endfunction

    function automatic logic parity_value(par_mode_e m, logic [CHAR_W-1:0] d);
        case (m)
            PAR_ODD:  return ~(^d);
            PAR_EVEN: return ^d;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         deep_en,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         overrun
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [CW-1:0] limit;
    logic          accept;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign limit  = deep_en ? CW'(DEPTH) : CW'(1);
    assign full   = (count >= limit);
    assign empty  = (count == '0);
    assign accept = push && !flush && (!full || pop);
    assign dout   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_ptr <= step(wr_ptr);
            if (pop)    rd_ptr <= step(rd_ptr);
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
            if (push && !accept) overrun <= 1'b1;
        end
    end

    a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !flush) |=> overrun);

    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  line_ctl_t         cfg_in,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              pop,
    output logic              txd
);

    localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(OVERSAMPLE - 1);

    tx_state_e         st;
    line_ctl_t         cfg_q;
    logic [TW-1:0]     tick_cnt;
    logic [2:0]        bit_idx;
    logic              stop_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_q;
    logic              bit_done;
    logic [CHAR_W-1:0] masked;

    assign pop      = (st == ST_IDLE) && !fifo_empty;
    assign bit_done = baud_tick && (tick_cnt == TICK_LAST);
    assign masked   = keep_low(fifo_data, cfg_in.len_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg_q    <= '0;
            tick_cnt <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_q    <= 1'b0;
        end else if (st == ST_IDLE) begin
            if (pop) begin
                cfg_q    <= cfg_in;
                shreg    <= masked;
                par_q    <= parity_value(cfg_in.par, masked);
                tick_cnt <= '0;
                st       <= ST_START;
            end
        end else if (baud_tick) begin
            tick_cnt <= bit_done ? '0 : tick_cnt + 1'b1;
            if (bit_done) begin
                case (st)
                    ST_START: begin
                        bit_idx <= '0;
                        st      <= ST_DATA;
                    end
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if ({1'b0, bit_idx} == char_bits(cfg_q.len_sel) - 4'd1) begin
                            stop_idx <= 1'b0;
                            st       <= parity_on(cfg_q.par) ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        stop_idx <= 1'b0;
                        st       <= ST_STOP;
                    end
                    ST_STOP: begin
                        if (cfg_q.two_stop && !stop_idx) stop_idx <= 1'b1;
                        else                             st       <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    a_r2_start_follows_pop: assert property (@(posedge clk) disable iff (rst)
        pop |=> !txd);

    a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !baud_tick) |=> $stable(txd));

    a_r6_cfg_frozen_in_frame: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(cfg_q));

endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              lcw_we,
    input  logic [LCW_W-1:0]  lcw_din,
    input  logic              fctl_we,
    input  logic [1:0]        fctl_din,
    input  logic              thr_we,
    input  logic [CHAR_W-1:0] thr_din,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_overrun
);

    localparam int FCTL_DEEP  = 0;
    localparam int FCTL_FLUSH = 1;

    line_ctl_t         lcw_q;
    logic              deep_q;
    logic              push, flush, pop, empty, full;
    logic [CHAR_W-1:0] head;

    always_ff @(posedge clk) begin
        if (rst) begin
            lcw_q  <= '0;
            deep_q <= 1'b0;
        end else begin
            if (lcw_we)  lcw_q  <= line_ctl_t'(lcw_din);
            if (fctl_we) deep_q <= fctl_din[FCTL_DEEP];
        end
    end

    assign push      = thr_we && !lcw_q.div_access;
    assign flush     = fctl_we && fctl_din[FCTL_FLUSH];
    assign thr_empty = empty;

    uart_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (CHAR_W)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .deep_en (deep_q),
        .push    (push),
        .din     (thr_din),
        .pop     (pop),
        .dout    (head),
        .empty   (empty),
        .full    (full),
        .overrun (tx_overrun)
    );

    uart_tx_shifter #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .cfg_in     (lcw_q),
        .fifo_empty (empty),
        .fifo_data  (head),
        .pop        (pop),
        .txd        (txd)
    );

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (fctl_we && fctl_din[FCTL_FLUSH]) |=> (thr_empty && !tx_overrun));

    a_r11_div_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (thr_we && lcw_q.div_access && thr_empty && !full) |=> thr_empty);

endmodule

// File: tb/uart_line_tx_test.sv
module uart_line_tx_test;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       lcw_we = 1'b0;
    logic [6:0] lcw_din = '0;
    logic       fctl_we = 1'b0;
    logic [1:0] fctl_din = '0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_din = '0;
    logic       txd, thr_empty, tx_overrun;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] got_a, got_b, exp_a, exp_b;
    logic [15:0] got_q [DEPTH+1];
    int          na, nb;

    always #10 clk = ~clk;   // 50 MHz

    uart_line_tx #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(16)) uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .lcw_we(lcw_we), .lcw_din(lcw_din),
        .fctl_we(fctl_we), .fctl_din(fctl_din),
        .thr_we(thr_we), .thr_din(thr_din),
        .txd(txd), .thr_empty(thr_empty), .tx_overrun(tx_overrun)
    );

    // stimulus/expectation vectors: {line-control word, data}
    localparam logic [14:0] VEC [0:8] = '{
        {7'b0_000_0_11, 8'hA5},  // 8 bits, none, 1 stop
        {7'b0_000_0_00, 8'hE9},  // 5 bits, upper bits ignored
        {7'b0_001_0_01, 8'h2D},  // 6 bits, odd
        {7'b0_010_0_10, 8'h5B},  // 7 bits, even
        {7'b0_011_1_11, 8'h00},  // 8 bits, forced 1, 2 stop
        {7'b0_100_0_11, 8'hFF},  // 8 bits, forced 0
        {7'b0_001_1_00, 8'h00},  // 5 bits, odd, 2 stop
        {7'b0_010_0_11, 8'h81},  // 8 bits, even
        {7'b0_110_0_11, 8'h3C}   // unused parity code -> none
    };

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: act=running exp=done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_bits(input logic [6:0] l, input logic [7:0] d,
                                      output logic [15:0] b);
        int n;
        int len;
        int ones;
        b = '1;
        n = 0;
        b[n] = 1'b0; n++;
        len = 5 + int'(l[1:0]);
        ones = 0;
        for (int i = 0; i < len; i++) begin
            b[n] = d[i]; n++;
            if (d[i]) ones++;
        end
        case (l[5:3])
            3'd1: begin b[n] = (ones % 2 == 0); n++; end
            3'd2: begin b[n] = (ones % 2 == 1); n++; end
            3'd3: begin b[n] = 1'b1; n++; end
            3'd4: begin b[n] = 1'b0; n++; end
            default: ;
        endcase
        b[n] = 1'b1; n++;
        if (l[2]) begin b[n] = 1'b1; n++; end
        return n;
    endfunction

    function automatic logic [15:0] msk(input int n);
        return 16'((32'h1 << n) - 1);
    endfunction

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (baud_tick !== 1'b1) @(posedge clk);
        end
    endtask

    // first_wait 8: wait for a falling edge; 16: continue from previous stop middle
    task automatic rx_frame(input int nbits, input int first_wait, output logic [15:0] got);
        got = '1;
        if (first_wait == 8) begin
            @(negedge clk);
            while (txd !== 1'b0) @(negedge clk);
        end
        for (int k = 0; k < nbits; k++) begin
            wait_ticks(k == 0 ? first_wait : 16);
            #1 got[k] = txd;
        end
    endtask

    task automatic set_lcw(input logic [6:0] v);
        @(negedge clk); lcw_we = 1'b1; lcw_din = v;
        @(negedge clk); lcw_we = 1'b0;
    endtask

    task automatic set_fctl(input logic [1:0] v);
        @(negedge clk); fctl_we = 1'b1; fctl_din = v;
        @(negedge clk); fctl_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); thr_we = 1'b1; thr_din = d;
    endtask

    task automatic bus_idle();
        @(negedge clk); thr_we = 1'b0;
    endtask

    task automatic line_quiet(input int cycles, output logic quiet);
        quiet = 1'b1;
        repeat (cycles) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
    endtask

    initial begin
        logic q;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle line", txd, 1'b1);
        chk("R1 holding empty", thr_empty, 1'b1);
        chk("R1 overrun clear", tx_overrun, 1'b0);

        // R2 R3 R4 R5 table walk
        for (int v = 0; v < 9; v++) begin
            logic [6:0] l;
            logic [7:0] d;
            int n;
            {l, d} = VEC[v];
            set_lcw(l);
            n = frame_bits(l, d, exp_a);
            fork
                rx_frame(n, 8, got_a);
                begin push(d); bus_idle(); end
            join
            chk($sformatf("R2 R3 R4 R5 vector %0d", v), 32'(got_a & msk(n)), 32'(exp_a & msk(n)));
            wait_ticks(12);
        end

        // R6 and R12: config change mid-character, back-to-back frames
        set_lcw(7'b0_000_0_11);
        na = frame_bits(7'b0_000_0_11, 8'h3C, exp_a);
        nb = frame_bits(7'b0_010_1_00, 8'hC3, exp_b);
        fork
            begin
                rx_frame(na, 8, got_a);
                rx_frame(nb, 16, got_b);
            end
            begin
                push(8'h3C); push(8'hC3); bus_idle();
                repeat (40) @(negedge clk);
                lcw_we = 1'b1; lcw_din = 7'b0_010_1_00;
                @(negedge clk); lcw_we = 1'b0;
            end
        join
        chk("R6 in-flight frame keeps old framing", 32'(got_a & msk(na)), 32'(exp_a & msk(na)));
        chk("R6 R12 next frame new framing, no gap", 32'(got_b & msk(nb)), 32'(exp_b & msk(nb)));
        wait_ticks(12);

        // R7: holding empty rises once the character is picked up
        set_lcw(7'b0_000_0_11);
        push(8'h99); bus_idle();
        @(negedge clk);
        chk("R7 empty while character on line", thr_empty, 1'b1);
        chk("R2 start bit low", txd, 1'b0);
        wait_ticks(170);

        // R8 R9 R10 with shallow queue
        na = frame_bits(7'b0_000_0_11, 8'h11, exp_a);
        fork
            rx_frame(na, 8, got_a);
            begin
                push(8'h11); push(8'h22); bus_idle();
                chk("R7 queue holds one", thr_empty, 1'b0);
                chk("R8 two writes fit shallow queue", tx_overrun, 1'b0);
                push(8'h33); bus_idle();
                chk("R9 third write overruns", tx_overrun, 1'b1);
                repeat (5) @(negedge clk);
                chk("R9 overrun sticky", tx_overrun, 1'b1);
                set_fctl(2'b10);
                chk("R10 flush empties queue", thr_empty, 1'b1);
                chk("R10 flush clears overrun", tx_overrun, 1'b0);
            end
        join
        chk("R10 in-flight frame completes", 32'(got_a & msk(na)), 32'(exp_a & msk(na)));
        line_quiet(120, q);
        chk("R10 flushed characters never sent", q, 1'b1);

        // R8 R9 with deep queue
        set_fctl(2'b01);
        fork
            begin
                for (int i = 0; i <= DEPTH; i++) rx_frame(10, (i == 0) ? 8 : 16, got_q[i]);
            end
            begin
                for (int i = 0; i <= DEPTH; i++) push(8'h40 + 8'(i));
                bus_idle();
                chk("R8 deep queue takes FIFO_DEPTH plus one", tx_overrun, 1'b0);
                push(8'h77); bus_idle();
                chk("R9 overrun on full deep queue", tx_overrun, 1'b1);
                chk("R7 full queue not empty", thr_empty, 1'b0);
            end
        join
        for (int i = 0; i <= DEPTH; i++) begin
            na = frame_bits(7'b0_000_0_11, 8'h40 + 8'(i), exp_a);
            chk($sformatf("R8 R12 queued frame %0d", i), 32'(got_q[i] & msk(na)), 32'(exp_a & msk(na)));
        end
        wait_ticks(12);
        chk("R7 empty after drain", thr_empty, 1'b1);
        set_fctl(2'b11);
        chk("R9 overrun cleared by flush", tx_overrun, 1'b0);

        // R11 divisor access blocks data writes
        set_lcw(7'b1_000_0_11);
        push(8'h55); bus_idle();
        chk("R11 write not queued", thr_empty, 1'b1);
        line_quiet(100, q);
        chk("R11 no frame sent", q, 1'b1);
        set_lcw(7'b0_000_0_11);
        line_quiet(40, q);
        chk("R11 nothing released after clearing access", q, 1'b1);

        summary();
        $finish;
    end

endmodule